// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for one burst of a synchronous burst memory. A burst opens when either of two load strobes is seen at a rising clock edge: one driven by a processor, one driven by a cache controller. On that edge the external start address is stored and the step count is cleared. After that, the block computes the next addresses itself. The step count moves forward only on edges where the advance input is high.

A 2-bit step count (width `CW`) means one burst covers four words. The upper address bits never change during a burst. The order select input chooses how the count is mixed into the low bits. When it is low, the count is added to the loaded low bits, modulo four. When it is high, the count is XORed with them. A one-cycle wrap pulse marks the point where the fourth advance brings the sequence back to its start word. The order select is meant to be static; a pin left floating at board level should be tied high, which selects XOR order.

The reset input is asynchronous and active low. Inside the block its release is synchronized to the clock, so the block leaves reset two clock edges after the input goes high.

Top module: `burst_seq`

## Requirements
- R1: While reset is held, and until its release has been synchronized, `addr_out` is 0 and `wrap_pulse` is 0.
- R2: When `proc_strobe` is high at a rising edge, `addr_out` equals the sampled `start_addr` after that edge, and the step count is zero.
- R3: `cache_strobe` loads the address in the same way as `proc_strobe`. When both strobes are high together, a single load takes place.
- R4: On an edge with no strobe and `advance` low, `addr_out` keeps its value.
- R5: With `order_sel` = 0, the low `CW` bits of `addr_out` equal (loaded low bits + step count) mod 4. A start of 2 gives 2,3,0,1.
- R6: With `order_sel` = 1, the low `CW` bits of `addr_out` equal the loaded low bits XOR the step count. A start of 1 gives 1,0,3,2.
- R7: Bits `AW-1` down to `CW` of `addr_out` change only when a strobe loads a new address.
- R8: A strobe wins over `advance` in the same cycle. It reloads the address with a step count of zero and never raises `wrap_pulse`.
- R9: On the edge where the fourth advance of a burst moves the step count from 3 back to 0, `wrap_pulse` goes high for exactly one cycle. On that same edge the low bits return to the start word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | AW | Burst start address, sampled when a strobe is high |
| proc_strobe | input | 1 | Load strobe from the processor |
| cache_strobe | input | 1 | Load strobe from the cache controller |
| advance | input | 1 | Steps the burst count by one |
| order_sel | input | 1 | 0 = add order, 1 = XOR order |
| addr_out | output | AW | Current word address |
| wrap_pulse | output | 1 | One-cycle pulse when the burst returns to its start word |

## Verification
A strobe or an advance that is sampled at an edge shows up on `addr_out` and `wrap_pulse` right after that same edge. The outputs have one register stage of delay and no more. The exception is `order_sel`: it acts on `addr_out` through combinational logic, with no clock edge involved. The bench changes its inputs on the falling edge. On each rising edge, a behavioural model updates its own state from the inputs the design samples. The bench compares the outputs on the next falling edge, so every result is checked in the exact half-cycle in which it is due. Reset release is synchronized inside the block, so the bench keeps all inputs idle for three cycles after `rst_n` rises.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    ORD_ADD = 1'b0,
    ORD_XOR = 1'b1
  } bsq_order_e;
endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  logic [AW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/bsq_counter.sv
module bsq_counter #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = {CW{1'b1}};
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_nxt;
  logic          wrap_nxt;

  // a clear has priority over a step and never produces a wrap
  always_comb begin
    cnt_nxt  = cnt;
    wrap_nxt = 1'b0;
    if (clear) begin
      cnt_nxt = '0;
    end else if (step) begin
      cnt_nxt  = cnt + ONE;
      wrap_nxt = (cnt == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      wrap <= wrap_nxt;
    end
  end
endmodule

// File: rtl/bsq_map.sv
module bsq_map
  import bsq_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [CW-1:0] base_lo,
  input  logic [CW-1:0] cnt,
  input  bsq_order_e    order,
  output logic [CW-1:0] lo
);
  always_comb begin
    case (order)
      ORD_XOR: lo = base_lo ^ cnt;
      default: lo = base_lo + cnt;
    endcase
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bsq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_addr,
  input  logic          proc_strobe,
  input  logic          cache_strobe,
  input  logic          advance,
  input  logic          order_sel,
  output logic [AW-1:0] addr_out,
  output logic          wrap_pulse
);
  logic          rst_sync_n;
  logic          load;
  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] low_bits;

  assign load = proc_strobe | cache_strobe;

  bsq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bsq_base_reg #(.AW(AW)) u_base (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (load),
    .d       (start_addr),
    .q       (base_q)
  );

  bsq_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (load),
    .step  (advance),
    .cnt   (cnt_q),
    .wrap  (wrap_pulse)
  );

  bsq_map #(.CW(CW)) u_map (
    .base_lo (base_q[CW-1:0]),
    .cnt     (cnt_q),
    .order   (bsq_order_e'(order_sel)),
    .lo      (low_bits)
  );

  generate
    if (AW > CW) begin : g_upper
      assign addr_out = {base_q[AW-1:CW], low_bits};
    end else begin : g_low_only
      assign addr_out = low_bits;
    end
  endgenerate
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] start_addr,
  input logic          proc_strobe,
  input logic          cache_strobe,
  input logic          advance,
  input logic          order_sel,
  input logic [AW-1:0] addr_out,
  input logic          wrap_pulse
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // R2 R3
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe || cache_strobe) |=> addr_out == $past(start_addr));

  // R8
  strobe_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe || cache_strobe) |=> !wrap_pulse);

  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe && !cache_strobe && !advance) |=>
      (addr_out == $past(addr_out)) || (order_sel != $past(order_sel)));

  // R5
  add_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe && !cache_strobe && advance && !order_sel) |=>
      order_sel || (addr_out[CW-1:0] == $past(addr_out[CW-1:0]) + ONE));

  // R4
  idle_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance) |=> !wrap_pulse);

  generate
    if (AW > CW) begin : g_up
      // R7
      upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe && !cache_strobe) |=>
          addr_out[AW-1:CW] == $past(addr_out[AW-1:CW]));
    end
    if (CW > 1) begin : g_wr
      // R9
      wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);
    end
  endgenerate
endmodule

bind burst_seq burst_seq_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .start_addr   (start_addr),
  .proc_strobe  (proc_strobe),
  .cache_strobe (cache_strobe),
  .advance      (advance),
  .order_sel    (order_sel),
  .addr_out     (addr_out),
  .wrap_pulse   (wrap_pulse)
);

// File: tb/burst_seq_tb_top.sv
module burst_seq_tb_top;
  localparam int AW = 16;
  localparam int CW = 2;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] start_addr;
  logic          proc_strobe;
  logic          cache_strobe;
  logic          advance;
  logic          order_sel;
  logic [AW-1:0] addr_out;
  logic          wrap_pulse;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_base = 0;
  int m_cnt  = 0;
  int m_wrap = 0;

  burst_seq #(.AW(AW), .CW(CW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_addr   (start_addr),
    .proc_strobe  (proc_strobe),
    .cache_strobe (cache_strobe),
    .advance      (advance),
    .order_sel    (order_sel),
    .addr_out     (addr_out),
    .wrap_pulse   (wrap_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_cnt = 0; m_wrap = 0;
    end else if (proc_strobe || cache_strobe) begin
      m_base = int'(start_addr); m_cnt = 0; m_wrap = 0;
    end else if (advance) begin
      m_wrap = (m_cnt == 3) ? 1 : 0;
      m_cnt  = (m_cnt + 1) % 4;
    end else begin
      m_wrap = 0;
    end
  end

  function automatic int exp_low();
    int b;
    b = m_base % 4;
    if (order_sel) return b ^ m_cnt;
    return (b + m_cnt) % 4;
  endfunction

  task automatic check(input string tag);
    int exp_up;
    exp_up = m_base / 4;
    checks++;
    if (int'(addr_out[AW-1:CW]) != exp_up) begin
      errors++;
      $display("FAIL R7 (%s) upper bits: actual=%0h expected=%0h", tag, addr_out[AW-1:CW], exp_up);
    end
    checks++;
    if (int'(addr_out[CW-1:0]) != exp_low()) begin
      errors++;
      $display("FAIL %s low bits: actual=%0d expected=%0d", tag, addr_out[CW-1:0], exp_low());
    end
    checks++;
    if (int'(wrap_pulse) != m_wrap) begin
      errors++;
      $display("FAIL %s wrap_pulse: actual=%0d expected=%0d", tag, wrap_pulse, m_wrap);
    end
  endtask

  task automatic step(input logic ps, input logic cs, input logic adv,
                      input logic [AW-1:0] a, input string tag);
    proc_strobe  = ps;
    cache_strobe = cs;
    advance      = adv;
    start_addr   = a;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    rst_n = 1'b0; proc_strobe = 1'b0; cache_strobe = 1'b0;
    advance = 1'b0; order_sel = 1'b0; start_addr = '0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    step(0, 0, 0, 16'h0, "R1");
    step(0, 0, 0, 16'h0, "R1");
    step(0, 0, 0, 16'h0, "R1");

    // processor strobe, add order, start 2 -> 2,3,0,1,2
    step(1, 0, 0, 16'h1232, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 16'hFFFF, "R5");
    step(0, 0, 1, 16'hFFFF, "R9");
    step(0, 0, 0, 16'h0, "R4");
    step(0, 0, 0, 16'h5555, "R4");

    // cache strobe, XOR order, start 1 -> 1,0,3,2,1
    order_sel = 1'b1;
    step(0, 1, 0, 16'hABC1, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 16'h0, "R6");
    step(0, 0, 1, 16'h0, "R9");
    step(0, 0, 0, 16'h0, "R9");

    // both strobes together, then a strobe that overrides advance mid burst
    step(1, 1, 0, 16'h7F02, "R3");
    step(0, 0, 1, 16'h0, "R6");
    step(0, 0, 1, 16'h0, "R6");
    step(0, 0, 1, 16'h0, "R6");
    step(1, 0, 1, 16'h0303, "R8");
    step(0, 0, 1, 16'h0, "R6");
    order_sel = 1'b0;
    step(0, 1, 1, 16'hC0DE, "R8");
    step(0, 0, 1, 16'h0, "R5");

    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      if (i % 60 == 0) order_sel = ~order_sel;
      step(($urandom % 9) == 0, ($urandom % 11) == 0, ($urandom % 3) != 0,
           AW'($urandom), "R7");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule